// File: doc/BRIEF.md
# Segmented Address and Cartridge Bank Mapper

This block sits between a 16-bit processor and its memory system. On each access strobe it forms a 20-bit linear address from a segment and an offset: the segment is shifted left by four and the offset is added, and any carry beyond bit 19 is dropped. It then sorts the linear address into one of three targets: on-chip work memory, cartridge static RAM, or cartridge ROM.

For cartridge targets it builds a wider physical address from a set of bank registers. The 1 MB linear space is split into fixed windows. The lowest 64 KB is on-chip memory. The next 64 KB goes to static RAM through its own bank register. The next two 64 KB windows are ROM pages that can each be moved to any 64 KB-aligned page of ROM. The upper 768 KB is a large ROM window. Its register picks a 1 MB region of ROM, and only the top three quarters of that region can be reached. Software reloads the bank registers through a small write port. The results are registered and appear one clock after the strobe.

Top module: `seg_bank_mapper`

## Requirements
- R1: One clock after a cycle with `acc_valid` high, `lin_addr` equals (`seg` × 16 + `ofs`) modulo 2^20. A sum past 0xFFFFF wraps, so 0xFFFF:0x0010 gives 0x00000.
- R2: A linear address in 0x00000–0x0FFFF raises `sel_iram` only.
- R3: A linear address in 0x10000–0x1FFFF raises `sel_sram` only, and `sram_addr` = {static RAM bank, linear[15:0]}.
- R4: A linear address in 0x20000–0x2FFFF raises `sel_rom`, and `phys_addr` = {page bank A, linear[15:0]}. An address in 0x30000–0x3FFFF does the same using page bank B. With page bank B = 0x68, the access 0x3108:0x4240 gives 0x6852C0.
- R5: A linear address in 0x40000–0xFFFFF raises `sel_rom`, and `phys_addr` = {region bank, linear[19:0]}.
- R6: Exactly one select is high in the cycle after an access, and none is high otherwise. `phys_addr` is zero unless `sel_rom` is high. `sram_addr` is zero unless `sel_sram` is high.
- R7: While `rst` is high, every output is zero and every bank register is loaded with all ones. After reset, a page access therefore reaches the last 64 KB page of ROM.
- R8: When `wr_en` is high, `wr_data` is loaded into the register chosen by `wr_sel` (0 = region bank, 1 = static RAM bank, 2 = page bank A, 3 = page bank B). The region bank takes the low ROM_AW-20 bits and the static RAM bank takes the low SRAM_BANK_W bits. An access in the same cycle as the write still uses the old value. Later accesses use the new value, and the other registers keep their values.
- R9: ROM_AW = 24 addresses 16 MB. ROM_AW = 26 addresses 64 MB, with 10-bit page banks and a 6-bit region bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg | input | 16 | Segment value |
| ofs | input | 16 | Offset within the segment |
| acc_valid | input | 1 | Access strobe |
| wr_en | input | 1 | Bank register write enable |
| wr_sel | input | 2 | Bank register select (0 region, 1 static RAM, 2 page A, 3 page B) |
| wr_data | input | ROM_AW-16 | Bank register write value |
| lin_addr | output | 20 | Registered linear address |
| sel_iram | output | 1 | On-chip memory selected |
| sel_sram | output | 1 | Cartridge static RAM selected |
| sel_rom | output | 1 | Cartridge ROM selected |
| phys_addr | output | ROM_AW | Physical ROM address |
| sram_addr | output | 16+SRAM_BANK_W | Physical static RAM address |

## Verification
The properties assume that `seg`, `ofs` and `acc_valid` are known at every clock edge outside reset. They also assume that SRAM_BANK_W is no wider than ROM_AW-16, so the static RAM bank fits in the write word. The bench changes inputs only on falling edges and keeps the strobe low during reset. It uses the default and the 64 MB widths, both of which meet the width limit. Region edges, the 20-bit wrap and the write-versus-access ordering are driven as directed cases, each one strobed for a single cycle.

// File: rtl/segmap_pkg.sv
package segmap_pkg;

    localparam int LIN_W = 20;
    localparam int SEG_W = 16;
    localparam int OFS_W = 16;
    localparam int PAGE_W = 16;

    typedef enum logic [2:0] {
        RGN_IRAM,
        RGN_SRAM,
        RGN_ROM_A,
        RGN_ROM_B,
        RGN_ROM_WIDE
    } region_e;

    typedef enum logic [1:0] {
        BSEL_WIDE = 2'd0,
        BSEL_SRAM = 2'd1,
        BSEL_PAGE_A = 2'd2,
        BSEL_PAGE_B = 2'd3
    } bank_sel_e;

    typedef struct packed {
        logic iram;
        logic sram;
        logic rom;
    } sel_t;

    typedef struct packed {
        logic [LIN_W-1:0] lin;
        region_e          region;
    } xlate_t;

    function automatic logic [LIN_W-1:0] seg_to_lin(logic [SEG_W-1:0] s, logic [OFS_W-1:0] o);
        logic [LIN_W-1:0] base;
        base = {s, 4'h0};
        return base + {4'h0, o};
    endfunction

    function automatic region_e region_of(logic [LIN_W-1:0] lin);
        case (lin[LIN_W-1:PAGE_W])
            4'h0:    return RGN_IRAM;
            4'h1:    return RGN_SRAM;
            4'h2:    return RGN_ROM_A;
            4'h3:    return RGN_ROM_B;
            default: return RGN_ROM_WIDE;
        endcase
    endfunction

    function automatic sel_t sel_of(region_e r);
        sel_t s;
        s = '0;
        case (r)
            RGN_IRAM: s.iram = 1'b1;
            RGN_SRAM: s.sram = 1'b1;
            default:  s.rom  = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lin_addr_gen.sv
module lin_addr_gen
    import segmap_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [OFS_W-1:0] ofs,
    output xlate_t           xl
);
    always_comb begin
        xl.lin    = seg_to_lin(seg, ofs);
        xl.region = region_of(xl.lin);
    end
endmodule

// File: rtl/bank_file.sv
module bank_file
    import segmap_pkg::*;
#(
    parameter int ROM_AW      = 24,
    parameter int SRAM_BANK_W = 8,
    localparam int BW  = ROM_AW - PAGE_W,
    localparam int RBW = ROM_AW - LIN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [1:0]             wr_sel,
    input  logic [BW-1:0]          wr_data,
    output logic [RBW-1:0]         wide_bank,
    output logic [SRAM_BANK_W-1:0] sram_bank,
    output logic [BW-1:0]          page_bank [2]
);
    bank_sel_e target;
    assign target = bank_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            wide_bank <= '1;
            sram_bank <= '1;
        end else if (wr_en) begin
            if (target == BSEL_WIDE) wide_bank <= wr_data[RBW-1:0];
            if (target == BSEL_SRAM) sram_bank <= wr_data[SRAM_BANK_W-1:0];
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_page
        localparam bank_sel_e MY_SEL = (g == 0) ? BSEL_PAGE_A : BSEL_PAGE_B;
        always_ff @(posedge clk) begin
            if (rst)
                page_bank[g] <= '1;
            else if (wr_en && target == MY_SEL)
                page_bank[g] <= wr_data;
        end
    end
endmodule

// File: rtl/phys_mux.sv
module phys_mux
    import segmap_pkg::*;
#(
    parameter int ROM_AW      = 24,
    parameter int SRAM_BANK_W = 8,
    localparam int BW      = ROM_AW - PAGE_W,
    localparam int RBW     = ROM_AW - LIN_W,
    localparam int SRAM_AW = PAGE_W + SRAM_BANK_W
) (
    input  xlate_t                 xl,
    input  logic [RBW-1:0]         wide_bank,
    input  logic [SRAM_BANK_W-1:0] sram_bank,
    input  logic [BW-1:0]          page_bank [2],
    output logic [ROM_AW-1:0]      rom_pa,
    output logic [SRAM_AW-1:0]     sram_pa
);
    always_comb begin
        rom_pa  = '0;
        sram_pa = '0;
        case (xl.region)
            RGN_SRAM:     sram_pa = {sram_bank, xl.lin[PAGE_W-1:0]};
            RGN_ROM_A:    rom_pa  = {page_bank[0], xl.lin[PAGE_W-1:0]};
            RGN_ROM_B:    rom_pa  = {page_bank[1], xl.lin[PAGE_W-1:0]};
            RGN_ROM_WIDE: rom_pa  = {wide_bank, xl.lin};
            default: ;
        endcase
    end
endmodule

// File: rtl/seg_bank_mapper.sv
module seg_bank_mapper
    import segmap_pkg::*;
#(
    parameter int ROM_AW      = 24,
    parameter int SRAM_BANK_W = 8,
    localparam int BW      = ROM_AW - PAGE_W,
    localparam int RBW     = ROM_AW - LIN_W,
    localparam int SRAM_AW = PAGE_W + SRAM_BANK_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        seg,
    input  logic [15:0]        ofs,
    input  logic               acc_valid,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [BW-1:0]      wr_data,
    output logic [19:0]        lin_addr,
    output logic               sel_iram,
    output logic               sel_sram,
    output logic               sel_rom,
    output logic [ROM_AW-1:0]  phys_addr,
    output logic [SRAM_AW-1:0] sram_addr
);
    xlate_t                 xl;
    logic [RBW-1:0]         wide_bank;
    logic [SRAM_BANK_W-1:0] sram_bank;
    logic [BW-1:0]          page_bank [2];
    logic [ROM_AW-1:0]      rom_pa;
    logic [SRAM_AW-1:0]     sram_pa;
    sel_t                   sel_q;

    lin_addr_gen u_gen (
        .seg (seg),
        .ofs (ofs),
        .xl  (xl)
    );

    bank_file #(.ROM_AW(ROM_AW), .SRAM_BANK_W(SRAM_BANK_W)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .wide_bank (wide_bank),
        .sram_bank (sram_bank),
        .page_bank (page_bank)
    );

    phys_mux #(.ROM_AW(ROM_AW), .SRAM_BANK_W(SRAM_BANK_W)) u_mux (
        .xl        (xl),
        .wide_bank (wide_bank),
        .sram_bank (sram_bank),
        .page_bank (page_bank),
        .rom_pa    (rom_pa),
        .sram_pa   (sram_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_addr  <= '0;
            sel_q     <= '0;
            phys_addr <= '0;
            sram_addr <= '0;
        end else if (acc_valid) begin
            lin_addr  <= xl.lin;
            sel_q     <= sel_of(xl.region);
            phys_addr <= rom_pa;
            sram_addr <= sram_pa;
        end else begin
            sel_q     <= '0;
            phys_addr <= '0;
            sram_addr <= '0;
        end
    end

    assign sel_iram = sel_q.iram;
    assign sel_sram = sel_q.sram;
    assign sel_rom  = sel_q.rom;
endmodule

// File: rtl/seg_bank_mapper_chk.sv
module seg_bank_mapper_chk
    import segmap_pkg::*;
#(
    parameter int ROM_AW  = 24,
    parameter int SRAM_AW = 24
) (
    input logic               clk,
    input logic               rst,
    input logic [15:0]        seg,
    input logic [15:0]        ofs,
    input logic               acc_valid,
    input logic [19:0]        lin_addr,
    input logic               sel_iram,
    input logic               sel_sram,
    input logic               sel_rom,
    input logic [ROM_AW-1:0]  phys_addr,
    input logic [SRAM_AW-1:0] sram_addr
);
    logic [19:0] want_lin;
    assign want_lin = seg_to_lin(seg, ofs);

    assert_lin_sum_R1: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> lin_addr == $past(want_lin));

    assert_iram_range_R2: assert property (@(posedge clk) disable iff (rst)
        sel_iram |-> lin_addr[19:16] == 4'h0);

    assert_sram_range_R3: assert property (@(posedge clk) disable iff (rst)
        sel_sram |-> (lin_addr[19:16] == 4'h1 && sram_addr[15:0] == lin_addr[15:0]));

    assert_page_low_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_rom && lin_addr[19:18] == 2'b00) |-> phys_addr[15:0] == lin_addr[15:0]);

    assert_wide_low_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_rom && lin_addr[19:18] != 2'b00) |-> phys_addr[19:0] == lin_addr);

    assert_one_sel_R6: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> $countones({sel_iram, sel_sram, sel_rom}) == 1);

    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !(sel_iram || sel_sram || sel_rom));

    assert_zero_addr_R6: assert property (@(posedge clk) disable iff (rst)
        (!sel_rom |-> phys_addr == '0) and (!sel_sram |-> sram_addr == '0));

    assert_reset_out_R7: assert property (@(posedge clk)
        $past(rst) |-> (!sel_iram && !sel_sram && !sel_rom && lin_addr == '0));
endmodule

bind seg_bank_mapper seg_bank_mapper_chk #(.ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .seg       (seg),
    .ofs       (ofs),
    .acc_valid (acc_valid),
    .lin_addr  (lin_addr),
    .sel_iram  (sel_iram),
    .sel_sram  (sel_sram),
    .sel_rom   (sel_rom),
    .phys_addr (phys_addr),
    .sram_addr (sram_addr)
);

// File: tb/tb_seg_bank_mapper.sv
module tb_seg_bank_mapper;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] seg = '0;
    logic [15:0] ofs = '0;
    logic        acc_valid = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [9:0]  wr_data_w = '0;

    logic [19:0] lin_addr, lin_w;
    logic        sel_iram, sel_sram, sel_rom, wi, ws, wrm;
    logic [23:0] phys_addr, sram_addr, sram_w;
    logic [25:0] phys_w;

    int total = 0;
    int bad = 0;

    logic [3:0] m_wide = '1;
    logic [7:0] m_sram = '1;
    logic [7:0] m_pa = '1;
    logic [7:0] m_pb = '1;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_bank_mapper dut (
        .clk(clk), .rst(rst), .seg(seg), .ofs(ofs), .acc_valid(acc_valid),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lin_addr(lin_addr), .sel_iram(sel_iram), .sel_sram(sel_sram), .sel_rom(sel_rom),
        .phys_addr(phys_addr), .sram_addr(sram_addr)
    );

    seg_bank_mapper #(.ROM_AW(26)) dut_wide (
        .clk(clk), .rst(rst), .seg(seg), .ofs(ofs), .acc_valid(acc_valid),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data_w),
        .lin_addr(lin_w), .sel_iram(wi), .sel_sram(ws), .sel_rom(wrm),
        .phys_addr(phys_w), .sram_addr(sram_w)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        seg = s; ofs = o; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic write_bank(input logic [1:0] which, input logic [9:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = which; wr_data = v[7:0]; wr_data_w = v;
        @(negedge clk);
        wr_en = 1'b0;
        case (which)
            2'd0: m_wide = v[3:0];
            2'd1: m_sram = v[7:0];
            2'd2: m_pa = v[7:0];
            default: m_pb = v[7:0];
        endcase
    endtask

    // expected outputs from the requirements R1..R6
    task automatic expect_access(input string tag, input logic [15:0] s, input logic [15:0] o);
        logic [19:0] el;
        logic [2:0]  es;
        logic [23:0] ep, esr;
        el = {s, 4'h0} + {4'h0, o};
        ep = '0; esr = '0;
        case (el[19:16])
            4'h0: es = 3'b100;
            4'h1: begin es = 3'b010; esr = {m_sram, el[15:0]}; end
            4'h2: begin es = 3'b001; ep = {m_pa, el[15:0]}; end
            4'h3: begin es = 3'b001; ep = {m_pb, el[15:0]}; end
            default: begin es = 3'b001; ep = {m_wide, el}; end
        endcase
        strobe(s, o);
        chk({tag, " lin (R1)"}, 32'(lin_addr), 32'(el));
        chk({tag, " sel (R6)"}, 32'({sel_iram, sel_sram, sel_rom}), 32'(es));
        chk({tag, " phys"}, 32'(phys_addr), 32'(ep));
        chk({tag, " sram"}, 32'(sram_addr), 32'(esr));
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset sel", 32'({sel_iram, sel_sram, sel_rom}), 32'd0);
        chk("R7 reset lin", 32'(lin_addr), 32'd0);
        chk("R7 reset phys", 32'(phys_addr), 32'd0);
        rst = 1'b0;
        expect_access("R7 page A all ones", 16'h2000, 16'h0000);
        chk("R7 page A top", 32'(phys_addr), 32'hFF0000);
        expect_access("R7 wide all ones", 16'h4000, 16'h0000);
        chk("R7 wide top", 32'(phys_addr), 32'hF40000);
        expect_access("R7 sram all ones", 16'h1000, 16'h0123);
    endtask

    task automatic t_boundaries;
        expect_access("R2 iram low", 16'h0000, 16'h0000);
        expect_access("R2 iram top", 16'h0000, 16'hFFFF);
        expect_access("R3 sram low", 16'h1000, 16'h0000);
        expect_access("R3 sram top", 16'h1FFF, 16'h000F);
        expect_access("R4 page A low", 16'h2000, 16'h0000);
        expect_access("R4 page A top", 16'h2FFF, 16'h000F);
        expect_access("R4 page B low", 16'h3000, 16'h0000);
        expect_access("R4 page B top", 16'h3FFF, 16'h000F);
        expect_access("R5 wide low", 16'h4000, 16'h0000);
        expect_access("R5 wide top", 16'hF000, 16'hFFFF);
    endtask

    task automatic t_wrap;
        expect_access("R1 wrap to zero", 16'hFFFF, 16'h0010);
        chk("R1 wrap sel iram", 32'(sel_iram), 32'd1);
        expect_access("R1 wrap mid", 16'hFFF8, 16'h1234);
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h68; wr_data_w = 10'h068;
        seg = 16'h3108; ofs = 16'h4240; acc_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; acc_valid = 1'b0;
        chk("R8 same-cycle uses old bank", 32'(phys_addr), {8'h0, m_pb, 16'h52C0});
        m_pb = 8'h68;
        expect_access("R4 example", 16'h3108, 16'h4240);
        chk("R4 example value", 32'(phys_addr), 32'h6852C0);
        write_bank(2'd2, 10'h15);
        write_bank(2'd1, 10'h3C);
        write_bank(2'd0, 10'h27);
        expect_access("R8 page A new", 16'h2ABC, 16'h0001);
        expect_access("R8 page B kept", 16'h3000, 16'h0042);
        expect_access("R8 sram new", 16'h1800, 16'h0007);
        expect_access("R8 wide low bits", 16'h9000, 16'h0055);
        chk("R8 wide uses 4 bits", 32'(phys_addr), 32'h790055);
    endtask

    task automatic t_idle;
        strobe(16'h2000, 16'h0010);
        @(negedge clk);
        chk("R6 idle sel", 32'({sel_iram, sel_sram, sel_rom}), 32'd0);
        chk("R6 idle phys", 32'(phys_addr), 32'd0);
        chk("R6 idle sram", 32'(sram_addr), 32'd0);
    endtask

    task automatic t_wide;
        strobe(16'h4000, 16'h0000);
        chk("R9 wide region reset", 32'(phys_w), 32'h3F40000);
        write_bank(2'd3, 10'h3A5);
        strobe(16'h3000, 16'hBEEF);
        chk("R9 wide page B", 32'(phys_w), 32'h3A5BEEF);
        chk("R9 narrow page B", 32'(phys_addr), 32'hA5BEEF);
        write_bank(2'd0, 10'h2B);
        strobe(16'hC000, 16'h0001);
        chk("R9 wide region 6 bits", 32'(phys_w), 32'h2BC0001);
    endtask

    initial begin
        t_reset();
        t_boundaries();
        t_wrap();
        t_idle();
        t_wide();
        t_write_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule